// File: doc/BRIEF.md
# Host-Driven Gate Bit Sequencer

This block sits on the host side of a small slave controller's parallel host port. Each host write arrives as a one-cycle write-enable pulse together with an address line (high means command, low means data) and an 8-bit data byte. Normally every write is stored in an input buffer, and a buffer-full flag tells the internal CPU that a byte is waiting. The CPU clears the flag by pulsing a buffer-read signal.

Once the CPU turns on a hardware shortcut, the block looks for a two-step "write output port" sequence. The sequence is command D1h followed by one data byte. Bit 1 of that data byte goes straight to a single gate output pin, and the CPU is never involved. The buffer-full flag stays low for the whole sequence. A trailing FFh command is also absorbed, but only when it comes right after a valid sequence. Any write that breaks the pattern goes to the CPU as usual. While the shortcut is on, the CPU can no longer drive the pin.

Top module: `gate_seq_top`

## Requirements
- R1: After reset: `gate_pin`=1, `ibuf_full`=0, `ibuf_is_cmd`=0, `ibuf_data`=00h and `shortcut_on`=0. An `enable_cmd` pulse sets `shortcut_on` from the next cycle, and it stays 1 until reset. A write in the same cycle as `enable_cmd` is still handled as disabled.
- R2: While `shortcut_on`=0, `cpu_pin_we` loads `cpu_pin_val` into `gate_pin` one cycle later. While `shortcut_on`=1, `cpu_pin_we` has no effect on `gate_pin`.
- R3: While the shortcut is enabled, a command write (`host_is_cmd`=1) of D1h leaves `gate_pin` and `ibuf_full` unchanged and arms the sequence.
- R4: A data write (`host_is_cmd`=0) to an armed sequence copies `host_data[1]` into `gate_pin` one cycle later. The write does not touch the buffer. DFh sets the pin and DDh clears it.
- R5: No write that belongs to a valid sequence changes `ibuf_full`. This covers the D1h command, the data write and an absorbed FFh.
- R6: An FFh command right after the data write of a valid sequence is absorbed: `gate_pin` and the buffer are unchanged. An FFh command at any other time goes to the buffer.
- R7: A second D1h command while the sequence is armed is absorbed and keeps it armed. A following data write still updates `gate_pin`.
- R8: If an armed sequence receives a command other than D1h, the sequence is abandoned. That command goes to the buffer, the next data write also goes to the buffer, and `gate_pin` keeps its level.
- R9: Every write that is not absorbed (including all writes while disabled) loads `ibuf_data` with the byte and `ibuf_is_cmd` with the address line, and sets `ibuf_full`, all one cycle later.
- R10: A `buf_rd` pulse clears `ibuf_full` one cycle later. If a write is pushed into the buffer in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | One-cycle host write pulse |
| host_is_cmd | input | 1 | Address line of the write: 1 command, 0 data |
| host_data | input | 8 | Host write byte |
| enable_cmd | input | 1 | Pulse from the CPU that turns the shortcut on |
| cpu_pin_we | input | 1 | CPU write strobe to the gate pin |
| cpu_pin_val | input | 1 | Value the CPU writes to the gate pin |
| buf_rd | input | 1 | CPU read pulse that clears the buffer-full flag |
| ibuf_data | output | 8 | Byte held in the input buffer |
| ibuf_full | output | 1 | Buffer-full flag |
| ibuf_is_cmd | output | 1 | Address line of the buffered write |
| gate_pin | output | 1 | Gate output pin |
| shortcut_on | output | 1 | Shortcut enabled |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. This covers the pin update from a data write, the buffer load and flag set, the flag clear from `buf_rd`, and the enable. None of them has any longer pipeline.

The bench drives inputs on the falling edge and holds them through the rising edge. It then updates a behavioural model for that edge and compares all outputs on the following falling edge, so every check lands one edge after its cause. The test sequences cover set, clear, double-trigger, abandoned sequences and stray FFh commands, with idle cycles in between. These idle cycles show that nothing changes when no stimulus is applied.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;
  typedef enum logic [1:0] {
    TRK_IDLE  = 2'd0,
    TRK_ARMED = 2'd1,
    TRK_DONE  = 2'd2
  } trk_state_t;
endpackage

// File: rtl/gate_seq_tracker.sv
module gate_seq_tracker
  import gate_seq_pkg::*;
#(
  parameter int          DW        = 8,
  parameter logic [DW-1:0] OPEN_CODE = 8'hD1,
  parameter logic [DW-1:0] TAIL_CODE = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wr_en,
  input  logic          wr_cmd,
  input  logic [DW-1:0] wr_data,
  output logic          absorb,
  output logic          pin_load
);
  trk_state_t st, st_nx;
  logic is_open, is_tail;

  always_comb begin
    is_open  = wr_cmd && (wr_data == OPEN_CODE);
    is_tail  = wr_cmd && (wr_data == TAIL_CODE);
    pin_load = wr_en && en && !wr_cmd && (st == TRK_ARMED);
    absorb   = wr_en && en &&
               (is_open || pin_load || (is_tail && st == TRK_DONE));
  end

  always_comb begin
    st_nx = st;
    if (!en)               st_nx = TRK_IDLE;
    else if (wr_en) begin
      if (is_open)         st_nx = TRK_ARMED;
      else if (pin_load)   st_nx = TRK_DONE;
      else                 st_nx = TRK_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= TRK_IDLE;
    else     st <= st_nx;
  end

  // R8: a non-opening command while armed is never absorbed
  a_r8_abandon: assert property (@(posedge clk) disable iff (rst)
    (st == TRK_ARMED && wr_en && wr_cmd && wr_data != OPEN_CODE) |-> !absorb);
endmodule

// File: rtl/gate_seq_ibuf.sv
module gate_seq_ibuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          push_cmd,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] data,
  output logic          full,
  output logic          is_cmd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data   <= '0;
      full   <= 1'b0;
      is_cmd <= 1'b0;
    end else if (push) begin
      data   <= push_data;
      is_cmd <= push_cmd;
      full   <= 1'b1;
    end else if (pop) begin
      full   <= 1'b0;
    end
  end

  // R10: a read with no push clears the flag
  a_r10_pop_clears: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> !full);
  // R9: a push always leaves the flag set
  a_r9_push_sets: assert property (@(posedge clk) disable iff (rst)
    push |=> full);
endmodule

// File: rtl/gate_seq_pin.sv
module gate_seq_pin #(
  parameter logic PIN_RST = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic load,
  input  logic load_val,
  input  logic cpu_we,
  input  logic cpu_val,
  output logic pin
);
  always_ff @(posedge clk) begin
    if (rst)                pin <= PIN_RST;
    else if (en) begin
      if (load)             pin <= load_val;
    end else if (cpu_we)    pin <= cpu_val;
  end

  // R4: a sequence data write lands on the pin one cycle later
  a_r4_pin_follows: assert property (@(posedge clk) disable iff (rst)
    (en && load) |=> pin == $past(load_val));
  // R2: with the shortcut on, only a sequence load moves the pin
  a_r2_cpu_locked: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> $stable(pin));
endmodule

// File: rtl/gate_seq_top.sv
module gate_seq_top #(
  parameter int DW       = 8,
  parameter int PIN_BIT  = 1,
  parameter logic [DW-1:0] OPEN_CODE = 8'hD1,
  parameter logic [DW-1:0] TAIL_CODE = 8'hFF,
  parameter logic PIN_RST = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic          host_is_cmd,
  input  logic [DW-1:0] host_data,
  input  logic          enable_cmd,
  input  logic          cpu_pin_we,
  input  logic          cpu_pin_val,
  input  logic          buf_rd,
  output logic [DW-1:0] ibuf_data,
  output logic          ibuf_full,
  output logic          ibuf_is_cmd,
  output logic          gate_pin,
  output logic          shortcut_on
);
  logic absorb, pin_load, push;

  always_ff @(posedge clk) begin
    if (rst)             shortcut_on <= 1'b0;
    else if (enable_cmd) shortcut_on <= 1'b1;
  end

  gate_seq_tracker #(.DW(DW), .OPEN_CODE(OPEN_CODE), .TAIL_CODE(TAIL_CODE)) u_trk (
    .clk(clk), .rst(rst), .en(shortcut_on), .wr_en(host_we),
    .wr_cmd(host_is_cmd), .wr_data(host_data),
    .absorb(absorb), .pin_load(pin_load)
  );

  assign push = host_we && !absorb;

  gate_seq_ibuf #(.DW(DW)) u_buf (
    .clk(clk), .rst(rst), .push(push), .push_cmd(host_is_cmd),
    .push_data(host_data), .pop(buf_rd),
    .data(ibuf_data), .full(ibuf_full), .is_cmd(ibuf_is_cmd)
  );

  gate_seq_pin #(.PIN_RST(PIN_RST)) u_pin (
    .clk(clk), .rst(rst), .en(shortcut_on), .load(pin_load),
    .load_val(host_data[PIN_BIT]), .cpu_we(cpu_pin_we),
    .cpu_val(cpu_pin_val), .pin(gate_pin)
  );

  // R1: the enable is sticky until reset
  a_r1_sticky: assert property (@(posedge clk) disable iff (rst)
    shortcut_on |=> shortcut_on);
  // R3/R5: an opening command while enabled leaves the flag alone
  a_r5_open_quiet: assert property (@(posedge clk) disable iff (rst)
    (shortcut_on && host_we && host_is_cmd && host_data == OPEN_CODE && !buf_rd)
      |=> $stable(ibuf_full));
  // R9: while disabled every write reaches the buffer
  a_r9_disabled_fwd: assert property (@(posedge clk) disable iff (rst)
    (!shortcut_on && host_we) |=> (ibuf_full && ibuf_data == $past(host_data)));
endmodule

// File: tb/gate_seq_top_tb.sv
module gate_seq_top_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       host_we, host_is_cmd, enable_cmd, cpu_pin_we, cpu_pin_val, buf_rd;
  logic [7:0] host_data;
  logic [7:0] ibuf_data;
  logic       ibuf_full, ibuf_is_cmd, gate_pin, shortcut_on;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit       m_en, m_pin, m_full, m_cmd;
  bit [7:0] m_data;
  int       m_phase;   // 0 idle, 1 after D1, 2 after valid data

  always #4 clk = ~clk;

  gate_seq_top u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_is_cmd(host_is_cmd),
    .host_data(host_data), .enable_cmd(enable_cmd), .cpu_pin_we(cpu_pin_we),
    .cpu_pin_val(cpu_pin_val), .buf_rd(buf_rd), .ibuf_data(ibuf_data),
    .ibuf_full(ibuf_full), .ibuf_is_cmd(ibuf_is_cmd), .gate_pin(gate_pin),
    .shortcut_on(shortcut_on)
  );

  task automatic compare(input string tag);
    logic [11:0] act, exp;
    act = {gate_pin, ibuf_full, ibuf_is_cmd, shortcut_on, ibuf_data};
    exp = {m_pin, m_full, m_cmd, m_en, m_data};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pin/full/cmd/en/data actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model the edge, compare at next negedge
  task automatic step(input string tag, input bit we, input bit cmd, input bit [7:0] d,
                      input bit rd = 0, input bit en_i = 0, input bit cwe = 0,
                      input bit cval = 0);
    bit take, load;
    host_we = we; host_is_cmd = cmd; host_data = d; buf_rd = rd;
    enable_cmd = en_i; cpu_pin_we = cwe; cpu_pin_val = cval;
    @(posedge clk);
    take = 0; load = 0;
    if (we && m_en) begin
      if (cmd && d == 8'hD1) begin take = 1; m_phase = 1; end
      else if (!cmd && m_phase == 1) begin take = 1; load = 1; m_phase = 2; end
      else if (cmd && d == 8'hFF && m_phase == 2) begin take = 1; m_phase = 0; end
      else m_phase = 0;
    end
    if (m_en) begin
      if (load) m_pin = d[1];
    end else if (cwe) m_pin = cval;
    if (we && !take) begin m_full = 1; m_data = d; m_cmd = cmd; end
    else if (rd) m_full = 0;
    if (en_i) m_en = 1;
    @(negedge clk);
    host_we = 0; buf_rd = 0; enable_cmd = 0; cpu_pin_we = 0;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 8'h00);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; host_we = 0; host_is_cmd = 0; host_data = 0; buf_rd = 0;
    enable_cmd = 0; cpu_pin_we = 0; cpu_pin_val = 0;
    m_en = 0; m_pin = 1; m_full = 0; m_cmd = 0; m_data = 0; m_phase = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    compare("R1 reset");

    // disabled: all writes go to buffer, CPU drives pin
    step("R9 disabled D1 forwarded", 1, 1, 8'hD1);
    step("R9 disabled data forwarded", 1, 0, 8'hDD);
    step("R10 read clears", 0, 0, 0, 1);
    step("R2 cpu clears pin", 0, 0, 0, 0, 0, 1, 0);
    step("R2 cpu sets pin", 0, 0, 0, 0, 0, 1, 1);
    // enable in same cycle as a write: write still treated as disabled
    step("R1 enable with write", 1, 1, 8'hD1, 0, 1);
    step("R10 read clears", 0, 0, 0, 1);
    step("R2 cpu write ignored", 0, 0, 0, 0, 0, 1, 0);

    // clear sequence
    step("R3 open absorbed", 1, 1, 8'hD1);
    idle("R3 idle gap");
    step("R4 DDh clears pin", 1, 0, 8'hDD);
    step("R6 tail FFh absorbed", 1, 1, 8'hFF);
    // set sequence
    step("R3 open absorbed", 1, 1, 8'hD1);
    step("R4 DFh sets pin", 1, 0, 8'hDF);
    step("R5 tail quiet", 1, 1, 8'hFF);
    // stray FFh goes to CPU
    step("R6 stray FFh forwarded", 1, 1, 8'hFF);
    step("R10 read clears", 0, 0, 0, 1);
    // double trigger clear
    step("R7 first D1", 1, 1, 8'hD1);
    step("R7 second D1", 1, 1, 8'hD1);
    step("R7 data clears pin", 1, 0, 8'hFD);
    // invalid: D1 then other command then data
    step("R8 open", 1, 1, 8'hD1);
    step("R8 other command forwarded", 1, 1, 8'h12);
    step("R10 read clears", 0, 0, 0, 1);
    step("R8 data forwarded pin kept", 1, 0, 8'hDF);
    // data without open
    step("R9 lone data forwarded", 1, 0, 8'h02);
    // push and read together
    step("R10 push beats read", 1, 1, 8'h40, 1);
    step("R10 read clears", 0, 0, 0, 1);
    // D1 after tail, and FFh not right after data
    step("R3 open", 1, 1, 8'hD1);
    step("R6 FFh while armed forwarded", 1, 1, 8'hFF);
    step("R10 read clears", 0, 0, 0, 1);
    step("R5 open quiet", 1, 1, 8'hD1);
    step("R4 set via bit1", 1, 0, 8'h02);
    step("R2 cpu ignored again", 0, 0, 0, 0, 0, 1, 0);

    // reset returns to defaults and disables
    @(negedge clk); rst = 1;
    m_en = 0; m_pin = 1; m_full = 0; m_cmd = 0; m_data = 0; m_phase = 0;
    @(posedge clk); @(negedge clk); rst = 0;
    compare("R1 reset again");
    step("R2 cpu drives after reset", 0, 0, 0, 0, 0, 1, 0);
    step("R9 D1 forwarded after reset", 1, 1, 8'hD1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule